// File: doc/BRIEF.md
# Floating-point environment save/restore sequencer

This block moves the architectural environment of a floating-point unit between its own registers and memory, one word per clock cycle. The environment is the control word, status word, tag word, instruction pointer (offset and selector), operand pointer (offset and selector) and the 11-bit last opcode. The block holds these fields itself and presents them on output ports. The eight 80-bit data registers stay in an external register file, which the block reaches through an indexed read/write port.

A one-cycle `start` accepts a command, a processor mode, an operand size and a base byte address. All of them are latched at that moment. The sequencer then steps through the memory image. Save commands drive writes. Load commands take read data from the same cycle, since memory reads are combinational. The image layout depends on the mode and the operand size. Real-address layouts split each pointer across two words and pack the upper pointer bits next to the opcode. A full save returns the environment to its power-on defaults after the last word is written.

Top module: `fpu_env_xfer`

## Requirements
- R1: Command codes are 0 store environment, 1 save full, 2 load environment, 3 restore full. A `start` while idle raises `busy` on the next cycle. `busy` stays high for 7 cycles (environment commands) or 47 cycles (full commands), with one transfer per cycle. `done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R2: A `start` while `busy` is high is ignored. The running command keeps its length and its transfers.
- R3: Environment word k (k = 0..6) is at base + 4k for 32-bit size and base + 2k for 16-bit size. Writes happen only while busy. In 16-bit layouts, write data bits 31..16 are zero.
- R4: Mode 0 (protected) with 32-bit size uses this layout. Words 0..2 are control, status and tag in bits 15..0. Word 3 is the full instruction offset. Word 4 is {5'b0, opcode, instruction selector}. Word 5 is the full operand offset. Word 6 is {16'b0, operand selector}.
- R5: Real 32-bit layout. Word 3 is instruction pointer bits 15..0. Word 4 is {4'b0, ip[31:16], 1'b0, opcode}. Word 5 is operand pointer bits 15..0. Word 6 is {4'b0, dp[31:16], 12'b0}.
- R6: Protected 16-bit layout. Words 3..6 are instruction offset[15:0], instruction selector, operand offset[15:0] and operand selector. The opcode is not stored. A load in this layout leaves the opcode unchanged and zero-extends both offsets.
- R7: Real 16-bit layout. Word 4 is {ip[19:16], 1'b0, opcode}. Word 6 is {dp[19:16], 12'b0}. Words 3 and 5 hold pointer bits 15..0.
- R8: Modes 1 (real), 2 (virtual-8086) and 3 (system management) all use the real layout for the selected size.
- R9: Full commands move data registers 0..7 in order after the environment. Each register moves as five 16-bit words, least significant first. Word j of register i is at base + 28 + 10i + 2j (32-bit size) or base + 14 + 10i + 2j (16-bit size). `rf_idx` selects the register.
- R10: After a full save, the environment equals the defaults: control 0x037F, status 0, tag 0xFFFF, pointers, selectors and opcode 0. Storing the environment leaves it unchanged.
- R11: Loads unpack each field with the same layout used for saving. Reserved bits are ignored. A real-layout load leaves both selectors unchanged. A real 16-bit load clears pointer bits 31..20.
- R12: During a full restore, `rf_we` pulses once per register, on the transfer of its fifth word. `rf_wdata` then carries the assembled 80-bit value. Load commands never assert `mem_wr`.
- R13: After reset the environment holds the defaults of R10, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request pulse |
| cmd | input | 2 | Command code (R1) |
| mode | input | 2 | Processor mode: 0 protected, 1 real, 2 virtual-8086, 3 system management |
| size32 | input | 1 | 1 selects 32-bit layouts, 0 selects 16-bit layouts |
| base_addr | input | AW | Byte address of the image |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Byte address of the current transfer |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the same cycle as mem_addr |
| mem_wr | output | 1 | Write strobe |
| rf_idx | output | IW | Data register index |
| rf_rdata | input | REG_W | Data register read value, combinational on rf_idx |
| rf_we | output | 1 | Data register write enable |
| rf_wdata | output | REG_W | Data register write value |
| env_ctrl | output | 16 | Control word |
| env_stat | output | 16 | Status word |
| env_tag | output | 16 | Tag word |
| env_ip | output | 32 | Instruction pointer offset |
| env_ip_sel | output | 16 | Instruction pointer selector |
| env_dp | output | 32 | Operand pointer offset |
| env_dp_sel | output | 16 | Operand pointer selector |
| env_opc | output | 11 | Last opcode |

## Verification
The assertions assume that memory answers a read in the same cycle as the address, with no wait states. They also assume that `start` is a request the block may drop while busy, not one that must be held until accepted. The bench models memory and the register file as zero-latency arrays, so it keeps to both assumptions. It raises `start` for exactly one cycle per command, except for one deliberate extra pulse in the middle of a running sequence. Reserved and upper-half bits in the memory the bench loads from are filled with ones or junk patterns, so that the layouts are checked without relying on clean inputs.

// File: rtl/fpu_env_pkg.sv
package fpu_env_pkg;

    typedef enum logic [1:0] {
        CMD_STENV   = 2'd0,
        CMD_SAVE    = 2'd1,
        CMD_LDENV   = 2'd2,
        CMD_RESTORE = 2'd3
    } fe_cmd_e;

    typedef enum logic [1:0] {
        MODE_PROT = 2'd0,
        MODE_REAL = 2'd1,
        MODE_V86  = 2'd2,
        MODE_SMM  = 2'd3
    } fe_mode_e;

    localparam int unsigned ENV_SLOTS = 7;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] stat;
        logic [15:0] tag;
        logic [31:0] ip;
        logic [15:0] ip_sel;
        logic [31:0] dp;
        logic [15:0] dp_sel;
        logic [10:0] opc;
    } fe_env_t;

    function automatic fe_env_t env_default();
        fe_env_t e;
        e        = '0;
        e.ctrl   = 16'h037F;
        e.tag    = 16'hFFFF;
        return e;
    endfunction

endpackage

// File: rtl/fpu_env_addr.sv
module fpu_env_addr #(
    parameter int unsigned AW = 16,
    parameter int unsigned SW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic          wide,
    output logic [AW-1:0] addr
);
    import fpu_env_pkg::*;

    localparam logic [AW-1:0] ENV_BYTES16 = AW'(2 * ENV_SLOTS);

    logic [AW-1:0] step_a;
    logic [AW-1:0] offs;

    always_comb begin
        step_a = AW'(step);
        if (step < SW'(ENV_SLOTS)) begin
            offs = wide ? (step_a << 2) : (step_a << 1);
        end else begin
            // Data words are 2 bytes apart; the environment area is 28 or 14 bytes.
            offs = (step_a << 1) + (wide ? ENV_BYTES16 : '0);
        end
        addr = base + offs;
    end

endmodule

// File: rtl/fpu_env_pack.sv
module fpu_env_pack (
    input  fpu_env_pkg::fe_env_t env,
    input  logic [2:0]           slot,
    input  logic                 real_fmt,
    input  logic                 wide,
    output logic [31:0]          word
);
    always_comb begin
        word = '0;
        unique case (slot)
            3'd0: word = {16'b0, env.ctrl};
            3'd1: word = {16'b0, env.stat};
            3'd2: word = {16'b0, env.tag};
            3'd3: word = (wide && !real_fmt) ? env.ip : {16'b0, env.ip[15:0]};
            3'd4: begin
                if (wide && !real_fmt)      word = {5'b0, env.opc, env.ip_sel};
                else if (wide)              word = {4'b0, env.ip[31:16], 1'b0, env.opc};
                else if (!real_fmt)         word = {16'b0, env.ip_sel};
                else                        word = {16'b0, env.ip[19:16], 1'b0, env.opc};
            end
            3'd5: word = (wide && !real_fmt) ? env.dp : {16'b0, env.dp[15:0]};
            3'd6: begin
                if (!real_fmt)              word = {16'b0, env.dp_sel};
                else if (wide)              word = {4'b0, env.dp[31:16], 12'b0};
                else                        word = {16'b0, env.dp[19:16], 12'b0};
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/fpu_env_unpack.sv
module fpu_env_unpack (
    input  fpu_env_pkg::fe_env_t env_in,
    input  logic [2:0]           slot,
    input  logic                 real_fmt,
    input  logic                 wide,
    input  logic [31:0]          word,
    output fpu_env_pkg::fe_env_t env_out
);
    always_comb begin
        env_out = env_in;
        unique case (slot)
            3'd0: env_out.ctrl = word[15:0];
            3'd1: env_out.stat = word[15:0];
            3'd2: env_out.tag  = word[15:0];
            3'd3: begin
                if (wide && !real_fmt) env_out.ip       = word;
                else if (wide)         env_out.ip[15:0] = word[15:0];
                else                   env_out.ip       = {16'b0, word[15:0]};
            end
            3'd4: begin
                if (wide && !real_fmt) begin
                    env_out.ip_sel = word[15:0];
                    env_out.opc    = word[26:16];
                end else if (wide) begin
                    env_out.ip[31:16] = word[27:12];
                    env_out.opc       = word[10:0];
                end else if (!real_fmt) begin
                    env_out.ip_sel = word[15:0];
                end else begin
                    env_out.ip[19:16] = word[15:12];
                    env_out.opc       = word[10:0];
                end
            end
            3'd5: begin
                if (wide && !real_fmt) env_out.dp       = word;
                else if (wide)         env_out.dp[15:0] = word[15:0];
                else                   env_out.dp       = {16'b0, word[15:0]};
            end
            3'd6: begin
                if (!real_fmt)         env_out.dp_sel    = word[15:0];
                else if (wide)         env_out.dp[31:16] = word[27:12];
                else                   env_out.dp[19:16] = word[15:12];
            end
            default: env_out = env_in;
        endcase
    end

endmodule

// File: rtl/fpu_env_xfer.sv
module fpu_env_xfer #(
    parameter int unsigned AW     = 16,
    parameter int unsigned NREG   = 8,
    parameter int unsigned REG_W  = 80,
    parameter int unsigned PART_W = 16,
    localparam int unsigned IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic [1:0]        mode,
    input  logic              size32,
    input  logic [AW-1:0]     base_addr,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              mem_wr,
    output logic [IW-1:0]     rf_idx,
    input  logic [REG_W-1:0]  rf_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_wdata,
    output logic [15:0]       env_ctrl,
    output logic [15:0]       env_stat,
    output logic [15:0]       env_tag,
    output logic [31:0]       env_ip,
    output logic [15:0]       env_ip_sel,
    output logic [31:0]       env_dp,
    output logic [15:0]       env_dp_sel,
    output logic [10:0]       env_opc
);
    import fpu_env_pkg::*;

    localparam int unsigned PARTS     = REG_W / PART_W;
    localparam int unsigned PW        = (PARTS > 1) ? $clog2(PARTS) : 1;
    localparam int unsigned ACC_W     = REG_W - PART_W;
    localparam int unsigned STEPS_ALL = ENV_SLOTS + NREG * PARTS;
    localparam int unsigned SW        = $clog2(STEPS_ALL + 1);
    localparam logic [SW-1:0] LAST_ENV  = SW'(ENV_SLOTS - 1);
    localparam logic [SW-1:0] LAST_FULL = SW'(STEPS_ALL - 1);
    localparam logic [SW-1:0] FIRST_DAT = SW'(ENV_SLOTS);
    localparam logic [PW-1:0] LAST_PART = PW'(PARTS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [1:0]       cmd;
        logic             real_fmt;
        logic             wide;
        logic [AW-1:0]    base;
        logic [SW-1:0]    step;
        logic [IW-1:0]    ridx;
        logic [PW-1:0]    part;
        logic [ACC_W-1:0] acc;
        fe_env_t          env;
    } seq_t;

    seq_t s_d, s_q;

    logic          is_save;
    logic          is_full;
    logic          in_data;
    logic [2:0]    slot;
    logic [31:0]   env_word;
    logic [PART_W-1:0] dat_word;
    fe_env_t       env_unp;
    logic [SW-1:0] last_step;

    assign is_save   = !s_q.cmd[1];
    assign is_full   = s_q.cmd[0];
    assign in_data   = (s_q.step >= FIRST_DAT);
    assign slot      = s_q.step[2:0];
    assign last_step = is_full ? LAST_FULL : LAST_ENV;
    assign dat_word  = rf_rdata[s_q.part * PART_W +: PART_W];

    fpu_env_addr #(.AW(AW), .SW(SW)) addr_i (
        .base (s_q.base),
        .step (s_q.step),
        .wide (s_q.wide),
        .addr (mem_addr)
    );

    fpu_env_pack pack_i (
        .env      (s_q.env),
        .slot     (slot),
        .real_fmt (s_q.real_fmt),
        .wide     (s_q.wide),
        .word     (env_word)
    );

    fpu_env_unpack unpack_i (
        .env_in   (s_q.env),
        .slot     (slot),
        .real_fmt (s_q.real_fmt),
        .wide     (s_q.wide),
        .word     (mem_rdata),
        .env_out  (env_unp)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy     = 1'b1;
                s_d.cmd      = cmd;
                s_d.real_fmt = (mode != MODE_PROT);
                s_d.wide     = size32;
                s_d.base     = base_addr;
                s_d.step     = '0;
                s_d.ridx     = '0;
                s_d.part     = '0;
            end
        end else begin
            if (!is_save && !in_data) begin
                s_d.env = env_unp;
            end
            if (in_data) begin
                if (!is_save) begin
                    s_d.acc = {mem_rdata[PART_W-1:0], s_q.acc[ACC_W-1:PART_W]};
                end
                if (s_q.part == LAST_PART) begin
                    s_d.part = '0;
                    s_d.ridx = s_q.ridx + 1'b1;
                end else begin
                    s_d.part = s_q.part + 1'b1;
                end
            end
            s_d.step = s_q.step + 1'b1;
            if (s_q.step == last_step) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.cmd == CMD_SAVE) begin
                    s_d.env = env_default();
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.env <= env_default();
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign mem_wr    = s_q.busy && is_save;
    assign mem_wdata = in_data ? {{(32-PART_W){1'b0}}, dat_word} : env_word;
    assign rf_idx    = s_q.ridx;
    assign rf_we     = s_q.busy && (s_q.cmd == CMD_RESTORE) && in_data && (s_q.part == LAST_PART);
    assign rf_wdata  = {mem_rdata[PART_W-1:0], s_q.acc};

    assign env_ctrl   = s_q.env.ctrl;
    assign env_stat   = s_q.env.stat;
    assign env_tag    = s_q.env.tag;
    assign env_ip     = s_q.env.ip;
    assign env_ip_sel = s_q.env.ip_sel;
    assign env_dp     = s_q.env.dp;
    assign env_dp_sel = s_q.env.dp_sel;
    assign env_opc    = s_q.env.opc;

endmodule

// File: rtl/fpu_env_xfer_chk.sv
module fpu_env_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_wr,
    input logic rf_we
);
    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_fall_gives_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_write_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> busy);

    assert_rf_write_on_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy && !mem_wr));

endmodule

bind fpu_env_xfer fpu_env_xfer_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .mem_wr (mem_wr),
    .rf_we  (rf_we)
);

// File: tb/fpu_env_xfer_tb_top.sv
module fpu_env_xfer_tb_top;

    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [1:0]  mode = 2'd0;
    logic        size32 = 1'b1;
    logic [AW-1:0] base_addr = '0;
    logic        busy, done, mem_wr, rf_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [2:0]  rf_idx;
    logic [79:0] rf_rdata, rf_wdata;
    logic [15:0] env_ctrl, env_stat, env_tag, env_ip_sel, env_dp_sel;
    logic [31:0] env_ip, env_dp;
    logic [10:0] env_opc;

    logic [31:0] mem [256];
    logic [79:0] rf_arr [8];
    int wr_cnt = 0;
    int we_cnt = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign rf_rdata  = rf_arr[rf_idx];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (rf_we) begin
            rf_arr[rf_idx] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    fpu_env_xfer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .mode(mode),
        .size32(size32), .base_addr(base_addr), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .rf_idx(rf_idx), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .env_ctrl(env_ctrl), .env_stat(env_stat),
        .env_tag(env_tag), .env_ip(env_ip), .env_ip_sel(env_ip_sel),
        .env_dp(env_dp), .env_dp_sel(env_dp_sel), .env_opc(env_opc)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill_mem(input logic [31:0] pat);
        for (int i = 0; i < 256; i++) mem[i] = pat;
    endtask

    // Issues one command; optionally pulses start again in the middle.
    task automatic run_cmd(input logic [1:0] c, input logic [1:0] m, input logic w,
                           input logic [AW-1:0] b, input bit inject, output int cycles);
        @(negedge clk);
        start = 1'b1; cmd = c; mode = m; size32 = w; base_addr = b;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            if (inject && cycles == 3) begin
                start = 1'b1; cmd = 2'd1; mode = 2'd1; size32 = ~w; base_addr = 16'h0040;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R1 done pulse", 80'(done), 80'd1);
        @(negedge clk);
        check("R1 done single", 80'(done), 80'd0);
    endtask

    task automatic check_env(input string req, input logic [15:0] c, input logic [15:0] s,
                             input logic [15:0] t, input logic [31:0] ip, input logic [15:0] ips,
                             input logic [31:0] dp, input logic [15:0] dps, input logic [10:0] op);
        check(req, {env_ctrl, env_stat, env_tag}, {c, s, t});
        check(req, {env_ip, env_ip_sel, env_dp}, {ip, ips, dp});
        check(req, {env_dp_sel, env_opc}, {dps, op});
    endtask

    task automatic t_reset();
        check("R13 busy/done", {busy, done}, 80'd0);
        check_env("R13 defaults", 16'h037F, 16'h0, 16'hFFFF, 32'h0, 16'h0, 32'h0, 16'h0, 11'h0);
    endtask

    task automatic t_load_prot32();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        mem[0] = 32'hFFFF_027F; mem[4] = 32'hFFFF_4521; mem[8] = 32'hFFFF_A5C3;
        mem[12] = 32'h89AB_CDEF; mem[16] = 32'hFDA6_0123; mem[20] = 32'h1357_9BDF;
        mem[24] = 32'hFFFF_2468;
        wr_cnt = 0;
        run_cmd(2'd2, 2'd0, 1'b1, 16'h0000, 1'b0, cy);
        check("R1 env length", 80'(cy), 80'd7);
        check("R12 no write on load", 80'(wr_cnt), 80'd0);
        check_env("R11 R4 prot32 load", 16'h027F, 16'h4521, 16'hA5C3, 32'h89AB_CDEF,
                  16'h0123, 32'h1357_9BDF, 16'h2468, 11'h5A6);
    endtask

    task automatic t_store_real32(input logic [1:0] m, input string req);
        int cy;
        fill_mem(32'hCCCC_CCCC);
        wr_cnt = 0;
        run_cmd(2'd0, m, 1'b1, 16'h0080, 1'b0, cy);
        check({req, " write count"}, 80'(wr_cnt), 80'd7);
        check({req, " ctrl"}, 80'(mem[128]), 80'h0000_027F);
        check({req, " tag"},  80'(mem[136]), 80'h0000_A5C3);
        check({req, " ip lo"}, 80'(mem[140]), 80'h0000_CDEF);
        check({req, " ip hi opc"}, 80'(mem[144]), 80'h089A_B5A6);
        check({req, " dp lo"}, 80'(mem[148]), 80'h0000_9BDF);
        check({req, " dp hi"}, 80'(mem[152]), 80'h0135_7000);
        check("R10 store keeps env", {env_ip, env_opc}, {32'h89AB_CDEF, 11'h5A6});
    endtask

    task automatic t_store_prot16_inject();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        wr_cnt = 0;
        run_cmd(2'd0, 2'd0, 1'b0, 16'h0080, 1'b1, cy);
        check("R2 ignored start length", 80'(cy), 80'd7);
        check("R2 ignored start writes", 80'(wr_cnt), 80'd7);
        check("R2 no stray write", 80'(mem[64]), 80'hCCCC_CCCC);
        check("R3 R6 prot16 ctrl", 80'(mem[128]), 80'h0000_027F);
        check("R6 prot16 stat", 80'(mem[130]), 80'h0000_4521);
        check("R6 prot16 ip", 80'(mem[134]), 80'h0000_CDEF);
        check("R6 prot16 ipsel", 80'(mem[136]), 80'h0000_0123);
        check("R6 prot16 dp", 80'(mem[138]), 80'h0000_9BDF);
        check("R6 prot16 dpsel", 80'(mem[140]), 80'h0000_2468);
    endtask

    task automatic t_store_real16_v86();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        run_cmd(2'd0, 2'd2, 1'b0, 16'h0080, 1'b0, cy);
        check("R7 R8 v86 ip lo", 80'(mem[134]), 80'h0000_CDEF);
        check("R7 R8 v86 ip hi opc", 80'(mem[136]), 80'h0000_B5A6);
        check("R7 R8 v86 dp lo", 80'(mem[138]), 80'h0000_9BDF);
        check("R7 R8 v86 dp hi", 80'(mem[140]), 80'h0000_7000);
    endtask

    task automatic t_load_real16();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        mem[0] = 32'hDEAD_0363; mem[2] = 32'hDEAD_0001; mem[4] = 32'hDEAD_5555;
        mem[6] = 32'hDEAD_1111; mem[8] = 32'hDEAD_3FFF; mem[10] = 32'hDEAD_2222;
        mem[12] = 32'hDEAD_4ABC;
        run_cmd(2'd2, 2'd1, 1'b0, 16'h0000, 1'b0, cy);
        check_env("R11 R7 real16 load", 16'h0363, 16'h0001, 16'h5555, 32'h0003_1111,
                  16'h0123, 32'h0004_2222, 16'h2468, 11'h7FF);
    endtask

    task automatic t_load_prot16();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        mem[0] = 32'hDEAD_0A7F; mem[2] = 32'hDEAD_0002; mem[4] = 32'hDEAD_3333;
        mem[6] = 32'hDEAD_4444; mem[8] = 32'hDEAD_5555; mem[10] = 32'hDEAD_6666;
        mem[12] = 32'hDEAD_7777;
        run_cmd(2'd2, 2'd0, 1'b0, 16'h0000, 1'b0, cy);
        check_env("R6 prot16 load keeps opcode", 16'h0A7F, 16'h0002, 16'h3333, 32'h0000_4444,
                  16'h5555, 32'h0000_6666, 16'h7777, 11'h7FF);
    endtask

    task automatic t_save_full_prot32();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        for (int i = 0; i < 8; i++)
            rf_arr[i] = {16'hA000 + 16'(i), 16'hB000 + 16'(i), 16'hC000 + 16'(i),
                         16'hD000 + 16'(i), 16'hE000 + 16'(i)};
        wr_cnt = 0;
        run_cmd(2'd1, 2'd0, 1'b1, 16'h0000, 1'b0, cy);
        check("R1 full length", 80'(cy), 80'd47);
        check("R9 full write count", 80'(wr_cnt), 80'd47);
        check("R4 prot32 ctrl", 80'(mem[0]), 80'h0000_0A7F);
        check("R4 prot32 ip", 80'(mem[12]), 80'h0000_4444);
        check("R4 prot32 sel opc", 80'(mem[16]), 80'h07FF_5555);
        check("R4 prot32 dpsel", 80'(mem[24]), 80'h0000_7777);
        for (int i = 0; i < 8; i++) begin
            check("R9 data word 0", 80'(mem[28 + 10*i]),     80'(32'hE000 + i));
            check("R9 data word 2", 80'(mem[28 + 10*i + 4]), 80'(32'hC000 + i));
            check("R9 data word 4", 80'(mem[28 + 10*i + 8]), 80'(32'hA000 + i));
        end
        check_env("R10 reinit after save", 16'h037F, 16'h0, 16'hFFFF, 32'h0, 16'h0,
                  32'h0, 16'h0, 11'h0);
    endtask

    task automatic t_restore_real16();
        int cy;
        fill_mem(32'hCCCC_CCCC);
        mem[128] = 32'hBEEF_0272; mem[130] = 32'hBEEF_0100; mem[132] = 32'hBEEF_00FF;
        mem[134] = 32'hBEEF_9999; mem[136] = 32'hBEEF_5123; mem[138] = 32'hBEEF_8888;
        mem[140] = 32'hBEEF_6000;
        for (int i = 0; i < 8; i++)
            for (int p = 0; p < 5; p++)
                mem[128 + 14 + 10*i + 2*p] = 32'hBEEF_F000 + 32'(16*i + p);
        for (int i = 0; i < 8; i++) rf_arr[i] = '0;
        wr_cnt = 0;
        we_cnt = 0;
        run_cmd(2'd3, 2'd3, 1'b0, 16'h0080, 1'b0, cy);
        check("R1 restore length", 80'(cy), 80'd47);
        check("R12 restore no writes", 80'(wr_cnt), 80'd0);
        check("R12 rf write count", 80'(we_cnt), 80'd8);
        for (int i = 0; i < 8; i++)
            check("R12 R9 rf value", rf_arr[i],
                  {16'hF000 + 16'(16*i + 4), 16'hF000 + 16'(16*i + 3), 16'hF000 + 16'(16*i + 2),
                   16'hF000 + 16'(16*i + 1), 16'hF000 + 16'(16*i)});
        check_env("R11 R8 smm real16 restore env", 16'h0272, 16'h0100, 16'h00FF, 32'h0005_9999,
                  16'h0, 32'h0006_8888, 16'h0, 11'h123);
    endtask

    initial begin
        bit hung;
        hung = 1'b0;
        fill_mem('0);
        for (int i = 0; i < 8; i++) rf_arr[i] = '0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_load_prot32();
                t_store_real32(2'd1, "R5 real32");
                t_store_real32(2'd3, "R8 smm32");
                t_store_prot16_inject();
                t_store_real16_v86();
                t_load_real16();
                t_load_prot16();
                t_save_full_prot32();
                t_restore_real16();
            end
            begin
                repeat (20000) @(posedge clk);
                hung = 1'b1;
            end
        join_any
        disable fork;
        if (hung) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule